// File: doc/BRIEF.md
# Vertical-blank synchronized shadow register bank

This block holds the parameter registers of a video processor and sits between the decoded write port of a serial control bus and the registers the video path reads. Every register has two copies. The shadow copy takes bus data. The active copy drives the video path.

In immediate mode, a write updates both copies at once. In buffered mode, a write updates only the shadow copy, and the block marks an update as pending. The whole shadow set is copied into the active set at the next rising edge of the vertical-blank input. That input is first synchronized into the system clock domain. While an update is pending, `busy_o` is high. The bus front end uses this flag to withhold acknowledge, and the bank itself drops ordinary writes. The mode register is an exception: writes to it always take effect at once, even while an update is pending, so the bank can never be stuck in buffered mode.

The mode bit is bit 5 of register 12. At reset it reads 0, which is immediate mode.

Top module: `vblank_shadow_regs`

## Requirements
- R1: While rst_ni is low, and after it is released, every register reads 8'h01 and busy_o is 0.
- R2: With bit 5 of register 12 at 0, an accepted write to any register shows on regs_o one clock after the write edge, and busy_o stays 0.
- R3: With bit 5 of register 12 at 1, a write to any register other than 12 leaves regs_o unchanged until a commit. If vblank_i is high at clock edge k and low at edge k-1, the commit updates regs_o at edge k+2.
- R4: busy_o goes to 1 on the edge that takes a buffered write. It returns to 0 on the commit edge, unless a new buffered write is taken at that same edge.
- R5: While busy_o is 1, a write to any register other than 12 is dropped, except on a commit edge. After the commit, the register still holds its previous value.
- R6: A rising edge on vblank_i with no pending update changes no register and leaves busy_o at 0.
- R7: Only a rising edge of vblank_i commits. A buffered write made while vblank_i stays high waits for the next rising edge.
- R8: A write to register 12 updates both copies at once in either mode, is taken even while busy_o is 1, never sets busy_o, and is not overwritten by a later commit.
- R9: When a buffered write falls on the commit edge, the earlier pending data is committed first. The new data becomes the next pending update, and busy_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset (supply fail) |
| wr_en_i | input | 1 | Write strobe from the bus front end |
| wr_addr_i | input | 4 | Register index |
| wr_data_i | input | 8 | Write data |
| vblank_i | input | 1 | Vertical-blank level, asynchronous |
| regs_o | output | 128 | Active register values, register n at bits [8n+7:8n] |
| busy_o | output | 1 | Update pending; further writes are refused |

## Verification
The bench first makes single writes in immediate mode and checks that the new value appears after one edge. It then makes writes in buffered mode and checks that nothing moves until the synchronized blanking edge. The pending-state patterns follow: a second data write, which must be dropped, and a mode-register write, which must pass and survive the commit. Together these separate the lockout from the mode bypass. Blanking with nothing pending, blanking held high across a new write, and a write placed exactly on the commit edge separate true edge detection and commit-then-write ordering from designs that act on the level or let the write win.

// File: rtl/vsr_pkg.sv
package vsr_pkg;
  typedef enum logic [1:0] {
    WR_NONE = 2'd0,
    WR_IMM  = 2'd1,
    WR_BUF  = 2'd2,
    WR_CTRL = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/vsr_edge_sync.sv
module vsr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

  // R7: a level held high yields one pulse only
  p_single_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/vsr_wr_ctrl.sv
module vsr_wr_ctrl
  import vsr_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              buf_mode_i,
  input  logic              vb_rise_i,
  output wr_kind_e          kind_o,
  output logic              commit_o,
  output logic              busy_o
);
  logic pending_q;

  assign commit_o = vb_rise_i & pending_q;
  assign busy_o   = pending_q;

  always_comb begin
    kind_o = WR_NONE;
    if (wr_en_i) begin
      if (wr_addr_i == ADDR_W'(CTRL_ADDR))  kind_o = WR_CTRL;
      else if (pending_q && !commit_o)      kind_o = WR_NONE;
      else if (buf_mode_i)                  kind_o = WR_BUF;
      else                                  kind_o = WR_IMM;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pending_q <= 1'b0;
    else if (kind_o == WR_BUF)  pending_q <= 1'b1;
    else if (commit_o)          pending_q <= 1'b0;
  end

  p_busy_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(kind_o == WR_BUF));
  p_busy_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o && kind_o != WR_BUF |=> !busy_o);
  p_overlap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o && kind_o == WR_BUF |=> busy_o);
endmodule

// File: rtl/vsr_reg_bank.sv
module vsr_reg_bank
  import vsr_pkg::*;
#(
  parameter int          ADDR_W    = 4,
  parameter int          DATA_W    = 8,
  parameter int          CTRL_ADDR = 12,
  parameter int          BUF_BIT   = 5,
  parameter logic [7:0]  RST_VAL   = 8'h01,
  localparam int         NUM_REGS  = 1 << ADDR_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  wr_kind_e                   kind_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          data_i,
  input  logic                       commit_i,
  output logic [NUM_REGS*DATA_W-1:0] active_o,
  output logic [NUM_REGS*DATA_W-1:0] shadow_o,
  output logic                       buf_mode_o
);
  logic [DATA_W-1:0] act_q [NUM_REGS];
  logic [DATA_W-1:0] shd_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic hit;
    assign hit = (addr_i == ADDR_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          shd_q[i] <= DATA_W'(RST_VAL);
      else if (kind_i != WR_NONE && hit)    shd_q[i] <= data_i;
    end

    // a direct write overrides the commit copy on the same edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                            act_q[i] <= DATA_W'(RST_VAL);
      else if ((kind_i == WR_IMM || kind_i == WR_CTRL) && hit) act_q[i] <= data_i;
      else if (commit_i)                                      act_q[i] <= shd_q[i];
    end

    assign active_o[i*DATA_W +: DATA_W] = act_q[i];
    assign shadow_o[i*DATA_W +: DATA_W] = shd_q[i];
  end

  assign buf_mode_o = act_q[CTRL_ADDR][BUF_BIT];

  p_imm_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_i == WR_IMM |=> act_q[$past(addr_i)] == $past(data_i));
  p_ctrl_imm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_i == WR_CTRL |=> act_q[CTRL_ADDR] == $past(data_i));
  p_buf_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i && (kind_i == WR_BUF || kind_i == WR_NONE) |=> $stable(active_o));
endmodule

// File: rtl/vblank_shadow_regs.sv
module vblank_shadow_regs
  import vsr_pkg::*;
#(
  parameter int          ADDR_W      = 4,
  parameter int          DATA_W      = 8,
  parameter int          CTRL_ADDR   = 12,
  parameter int          BUF_BIT     = 5,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  RST_VAL     = 8'h01,
  localparam int         NUM_REGS    = 1 << ADDR_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  input  logic                       vblank_i,
  output logic [NUM_REGS*DATA_W-1:0] regs_o,
  output logic                       busy_o
);
  logic                       vb_rise;
  logic                       commit;
  logic                       buf_mode;
  wr_kind_e                   kind;
  logic [NUM_REGS*DATA_W-1:0] shadow;

  vsr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (vblank_i),
    .rise_o  (vb_rise)
  );

  vsr_wr_ctrl #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .buf_mode_i (buf_mode),
    .vb_rise_i  (vb_rise),
    .kind_o     (kind),
    .commit_o   (commit),
    .busy_o     (busy_o)
  );

  vsr_reg_bank #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
    .BUF_BIT(BUF_BIT), .RST_VAL(RST_VAL)
  ) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .kind_i     (kind),
    .addr_i     (wr_addr_i),
    .data_i     (wr_data_i),
    .commit_i   (commit),
    .active_o   (regs_o),
    .shadow_o   (shadow),
    .buf_mode_o (buf_mode)
  );

  p_locked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !vb_rise && wr_en_i && wr_addr_i != ADDR_W'(CTRL_ADDR) |=> $stable(shadow));
  p_idle_vb_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !wr_en_i |=> $stable(regs_o) && !busy_o);
endmodule

// File: tb/vblank_shadow_regs_tb_top.sv
module vblank_shadow_regs_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wr_en_i = 1'b0;
  logic [3:0]   wr_addr_i = '0;
  logic [7:0]   wr_data_i = '0;
  logic         vblank_i = 1'b0;
  logic [127:0] regs_o;
  logic         busy_o;
  int           n_chk = 0;
  int           n_err = 0;

  always #5 clk_i = ~clk_i;

  vblank_shadow_regs dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .vblank_i(vblank_i), .regs_o(regs_o), .busy_o(busy_o)
  );

  task automatic chk_reg(input int idx, input logic [7:0] exp, input string req);
    n_chk++;
    if (regs_o[idx*8 +: 8] !== exp) begin
      n_err++;
      $display("FAIL %s reg%0d actual %02h expected %02h", req, idx, regs_o[idx*8 +: 8], exp);
    end
  endtask

  task automatic chk_busy(input logic exp, input string req);
    n_chk++;
    if (busy_o !== exp) begin
      n_err++;
      $display("FAIL %s busy actual %b expected %b", req, busy_o, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic vb_pulse();
    @(negedge clk_i) vblank_i = 1'b1;
    repeat (4) @(negedge clk_i);
    vblank_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 16; i++) chk_reg(i, 8'h01, "R1");
    chk_busy(1'b0, "R1");
  endtask

  task automatic t_immediate();
    wr(4'd3, 8'hA5);
    chk_reg(3, 8'hA5, "R2");
    chk_busy(1'b0, "R2");
    wr(4'd0, 8'h3C);
    chk_reg(0, 8'h3C, "R2");
  endtask

  task automatic t_idle_vblank();
    vb_pulse();
    chk_reg(3, 8'hA5, "R6");
    chk_reg(0, 8'h3C, "R6");
    chk_busy(1'b0, "R6");
  endtask

  task automatic t_buffered();
    wr(4'd12, 8'h20);
    chk_reg(12, 8'h20, "R8");
    chk_busy(1'b0, "R8");
    wr(4'd5, 8'h77);
    chk_reg(5, 8'h01, "R3");
    chk_busy(1'b1, "R4");
    wr(4'd6, 8'h99);            // dropped by lockout
    wr(4'd12, 8'h21);           // mode register passes the lockout
    chk_reg(12, 8'h21, "R8");
    // commit latency: vblank high at edge k, update at k+2
    @(negedge clk_i) vblank_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    chk_reg(5, 8'h01, "R3");
    @(negedge clk_i);
    chk_reg(5, 8'h77, "R3");
    chk_busy(1'b0, "R4");
    chk_reg(6, 8'h01, "R5");
    chk_reg(12, 8'h21, "R8");
    repeat (2) @(negedge clk_i);
    vblank_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic t_level_held();
    @(negedge clk_i) vblank_i = 1'b1;
    repeat (4) @(negedge clk_i);
    wr(4'd7, 8'h55);
    repeat (4) @(negedge clk_i);
    chk_reg(7, 8'h01, "R7");
    chk_busy(1'b1, "R7");
    vblank_i = 1'b0;
    repeat (3) @(negedge clk_i);
    vb_pulse();
    chk_reg(7, 8'h55, "R7");
    chk_busy(1'b0, "R7");
  endtask

  task automatic t_overlap();
    wr(4'd8, 8'h11);
    @(negedge clk_i) vblank_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 4'd9; wr_data_i = 8'h22;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk_reg(8, 8'h11, "R9");
    chk_reg(9, 8'h01, "R9");
    chk_busy(1'b1, "R9");
    repeat (2) @(negedge clk_i);
    vblank_i = 1'b0;
    repeat (2) @(negedge clk_i);
    vb_pulse();
    chk_reg(9, 8'h22, "R9");
    chk_busy(1'b0, "R9");
  endtask

  task automatic t_back_immediate();
    wr(4'd12, 8'h00);
    wr(4'd2, 8'h44);
    chk_reg(2, 8'h44, "R2");
    chk_busy(1'b0, "R2");
  endtask

  initial begin
    #(200000 * 10);
    n_err++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_immediate();
    t_idle_vblank();
    t_buffered();
    t_level_held();
    t_overlap();
    t_back_immediate();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule